// File: doc/BRIEF.md
# Multicycle Accumulator Instruction Sequencer

This block is the control unit of a small accumulator processor, with the minimal datapath it steers. Every instruction is one byte. It is taken through a fixed chain of one-cycle states: fetch, decode, program-counter step, operand load, an arithmetic state that only ADD and SUB visit, and write-back. Write-back then hands control back to fetch. There is no overlap between instructions. The program counter changes only in its own step state, which comes right after decode.

The datapath holds the instruction register, the program counter, an accumulator, an operand latch, the ALU result register, a register file addressed by the operand field, and a latched output port. Program memory sits outside the block. It is read combinationally at the address the block presents. The input port is sampled during the load state of an IN instruction. The control unit drives the datapath through one packed bundle of strobes. The main strobes are also brought out as ports, so the bench can watch the sequence from outside.

Top module: `seq_core`

## Requirements
- R1: While reset is high and in the first fetch after it, the program address, accumulator and output port are zero, and every load, write, strobe and ALU output is low.
- R2: The program address holds its value except in the third cycle of each instruction. At the end of that cycle it advances by exactly one, wrapping modulo 2^PC_W.
- R3: States run fetch, decode, PC step, load, then ALU (only for ADD and SUB), then write-back, one cycle each. ADD and SUB take 6 cycles and every other instruction takes 5.
- R4: Instruction bits [7:5] are the opcode: 0 MOV, 1 IN, 2 OUT, 3 ADD, 4 SUB. Bits [4:0] select one of 32 registers.
- R5: MOV r loads register r into the accumulator.
- R6: IN r samples the input port in the load cycle, with the input strobe high for that single cycle, and stores the value into register r at write-back.
- R7: ADD r and SUB r set the accumulator to acc+r or acc-r modulo 256. ALU enable is high for exactly one cycle, with the operation output 0 for add and 1 for subtract.
- R8: OUT copies the accumulator to the output port at write-back. The port holds its value in every other cycle.
- R9: Opcodes 5, 6 and 7 take 5 cycles, never enable the ALU, assert no write strobe and change no state.
- R10: Each defined instruction asserts exactly one write strobe, only in its write-back cycle. The write-target output reads 0 none, 1 accumulator, 2 register, 3 output port, and matches the strobe that is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | 8 | Program memory data at progAddr |
| inPort | input | 8 | Input port value |
| progAddr | output | 8 | Program memory address (program counter) |
| outPort | output | 8 | Latched output port |
| accOut | output | 8 | Accumulator value |
| regLoad | output | 1 | Operand latch load (load state) |
| inStrobe | output | 1 | Input port read strobe |
| aluEn | output | 1 | ALU operation enable |
| aluOp | output | 1 | ALU operation: 0 add, 1 subtract |
| accWe | output | 1 | Accumulator write strobe |
| regWe | output | 1 | Register file write strobe |
| outStrobe | output | 1 | Output port write strobe |
| wbSel | output | 2 | Write-back target code |

## Verification
Instruction lengths are measured as the gap between program-address steps. A sequencer that sends MOV, IN or OUT through the ALU state, or skips it for ADD or SUB, therefore shows a 6 or a 5 where the other is expected. Undefined opcodes are placed between live instructions. A decoder that lets them write would corrupt the accumulator or the output, and the next OUT would show it. SUB results that go below zero, and ADD results that carry out, check the modulo-256 wrap. The output port is compared on every cycle, so a port that changes outside write-back or latches the wrong source is caught at once.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_MOV = 3'd0;
  localparam logic [OPC_W-1:0] OPC_IN  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_OUT = 3'd2;
  localparam logic [OPC_W-1:0] OPC_ADD = 3'd3;
  localparam logic [OPC_W-1:0] OPC_SUB = 3'd4;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_PCSTEP = 3'd2,
    ST_LOAD   = 3'd3,
    ST_ALU    = 3'd4,
    ST_WRITE  = 3'd5
  } seqState_e;

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_ACC  = 2'd1,
    WB_REG  = 2'd2,
    WB_PORT = 2'd3
  } wbSel_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_IN  = 2'd1,
    SRC_ACC = 2'd2
  } opSrc_e;

  typedef struct packed {
    logic   instrLoad;
    logic   pcInc;
    logic   opLoad;
    opSrc_e opSrc;
    logic   aluEn;
    logic   aluSub;
    logic   accFromAlu;
    wbSel_e wbSel;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output seqStrobe_t       strobe
);

  seqState_e state, stateNext;
  logic      isArith;
  logic      isKnown;

  assign isArith = (opcode == OPC_ADD) || (opcode == OPC_SUB);
  assign isKnown = isArith || (opcode == OPC_MOV) || (opcode == OPC_IN) ||
                   (opcode == OPC_OUT);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    unique case (state)
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: stateNext = ST_PCSTEP;
      ST_PCSTEP: stateNext = ST_LOAD;
      ST_LOAD:   stateNext = isArith ? ST_ALU : ST_WRITE;
      ST_ALU:    stateNext = ST_WRITE;
      ST_WRITE:  stateNext = ST_FETCH;
      default:   stateNext = ST_FETCH;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.opSrc = SRC_REG;
    strobe.wbSel = WB_NONE;
    case (state)
      ST_FETCH:  strobe.instrLoad = 1'b1;
      ST_PCSTEP: strobe.pcInc = 1'b1;
      ST_LOAD: begin
        strobe.opLoad = isKnown;
        if (opcode == OPC_IN)       strobe.opSrc = SRC_IN;
        else if (opcode == OPC_OUT) strobe.opSrc = SRC_ACC;
        else                        strobe.opSrc = SRC_REG;
      end
      ST_ALU: begin
        strobe.aluEn  = 1'b1;
        strobe.aluSub = (opcode == OPC_SUB);
      end
      ST_WRITE: begin
        strobe.accFromAlu = isArith;
        if (isArith || opcode == OPC_MOV) strobe.wbSel = WB_ACC;
        else if (opcode == OPC_IN)        strobe.wbSel = WB_REG;
        else if (opcode == OPC_OUT)       strobe.wbSel = WB_PORT;
        else                              strobe.wbSel = WB_NONE;
      end
      default: ;
    endcase
  end

  // R3: fixed state order
  a_r3_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> state == ST_DECODE);
  a_r3_decode_to_step: assert property (@(posedge clk) disable iff (rst)
    state == ST_DECODE |=> state == ST_PCSTEP);
  a_r3_step_to_load: assert property (@(posedge clk) disable iff (rst)
    state == ST_PCSTEP |=> state == ST_LOAD);
  a_r3_arith_via_alu: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && isArith) |=> state == ST_ALU);
  a_r9_other_skip_alu: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && !isArith) |=> state == ST_WRITE);
  a_r3_alu_to_write: assert property (@(posedge clk) disable iff (rst)
    state == ST_ALU |=> state == ST_WRITE);
  a_r3_write_to_fetch: assert property (@(posedge clk) disable iff (rst)
    state == ST_WRITE |=> state == ST_FETCH);
  // R10: write targets only in write-back
  a_r10_wb_only_in_write: assert property (@(posedge clk) disable iff (rst)
    strobe.wbSel != WB_NONE |-> state == ST_WRITE);

endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8,
  parameter int OPD_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  seqStrobe_t             strobe,
  input  logic [OPC_W+OPD_W-1:0] instrWord,
  input  logic [DATA_W-1:0]      inPort,
  output logic [PC_W-1:0]        progAddr,
  output logic [OPC_W-1:0]       opcode,
  output logic [DATA_W-1:0]      outPort,
  output logic [DATA_W-1:0]      accOut
);

  localparam int IW   = OPC_W + OPD_W;
  localparam int NREG = 1 << OPD_W;

  logic [IW-1:0]     instrReg;
  logic [PC_W-1:0]   pc;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] aluRes;
  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] regFile [NREG];
  logic [OPD_W-1:0]  opAddr;
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] aluNext;
  logic [DATA_W-1:0] accWrData;

  assign opAddr   = instrReg[OPD_W-1:0];
  assign opcode   = instrReg[IW-1 -: OPC_W];
  assign progAddr = pc;
  assign outPort  = outReg;
  assign accOut   = acc;

  always_comb begin
    case (strobe.opSrc)
      SRC_IN:  srcVal = inPort;
      SRC_ACC: srcVal = acc;
      default: srcVal = regFile[opAddr];
    endcase
  end

  assign aluNext   = strobe.aluSub ? (acc - opnd) : (acc + opnd);
  assign accWrData = strobe.accFromAlu ? aluRes : opnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      instrReg <= '0;
      pc       <= '0;
      acc      <= '0;
      opnd     <= '0;
      aluRes   <= '0;
      outReg   <= '0;
    end else begin
      if (strobe.instrLoad)        instrReg <= instrWord;
      if (strobe.pcInc)            pc       <= pc + PC_W'(1);
      if (strobe.opLoad)           opnd     <= srcVal;
      if (strobe.aluEn)            aluRes   <= aluNext;
      if (strobe.wbSel == WB_ACC)  acc      <= accWrData;
      if (strobe.wbSel == WB_PORT) outReg   <= opnd;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regFile[g] <= '0;
      else if (strobe.wbSel == WB_REG && opAddr == OPD_W'(g)) regFile[g] <= opnd;
    end
  end

  // R2: program counter steps once, holds otherwise
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    strobe.pcInc |=> progAddr == PC_W'($past(progAddr) + PC_W'(1)));
  a_r2_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.pcInc |=> $stable(progAddr));
  // R8: output port loads accumulator only at OUT write-back
  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    strobe.wbSel != WB_PORT |=> $stable(outPort));
  a_r8_out_from_acc: assert property (@(posedge clk) disable iff (rst)
    (strobe.opLoad && strobe.opSrc == SRC_ACC) |=> opnd == $past(acc));
  // R9: accumulator untouched unless write-back targets it
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (rst)
    strobe.wbSel != WB_ACC |=> $stable(accOut));

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8,
  parameter int OPD_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OPC_W+OPD_W-1:0] instrWord,
  input  logic [DATA_W-1:0]      inPort,
  output logic [PC_W-1:0]        progAddr,
  output logic [DATA_W-1:0]      outPort,
  output logic [DATA_W-1:0]      accOut,
  output logic                   regLoad,
  output logic                   inStrobe,
  output logic                   aluEn,
  output logic                   aluOp,
  output logic                   accWe,
  output logic                   regWe,
  output logic                   outStrobe,
  output logic [1:0]             wbSel
);

  seqStrobe_t       strobe;
  logic [OPC_W-1:0] opcode;

  seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .strobe (strobe)
  );

  seq_dpath #(
    .DATA_W (DATA_W),
    .PC_W   (PC_W),
    .OPD_W  (OPD_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .instrWord (instrWord),
    .inPort    (inPort),
    .progAddr  (progAddr),
    .opcode    (opcode),
    .outPort   (outPort),
    .accOut    (accOut)
  );

  assign regLoad   = strobe.opLoad;
  assign inStrobe  = strobe.opLoad && (strobe.opSrc == SRC_IN);
  assign aluEn     = strobe.aluEn;
  assign aluOp     = strobe.aluSub;
  assign accWe     = (strobe.wbSel == WB_ACC);
  assign regWe     = (strobe.wbSel == WB_REG);
  assign outStrobe = (strobe.wbSel == WB_PORT);
  assign wbSel     = strobe.wbSel;

  // R10: at most one write strobe per cycle
  a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0({accWe, regWe, outStrobe}));
  // R7: ALU enable lasts a single cycle
  a_r7_alu_single: assert property (@(posedge clk) disable iff (rst)
    aluEn |=> !aluEn);

endmodule

// File: tb/seq_core_tb.sv
module seq_core_tb;

  typedef struct {
    int len;
    int writes;
    int alus;
    int ins;
    int sub;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] instrWord;
  logic [7:0] inPort;
  logic [7:0] progAddr, outPort, accOut;
  logic       regLoad, inStrobe, aluEn, aluOp, accWe, regWe, outStrobe;
  logic [1:0] wbSel;

  logic [7:0] prog [64];
  expItem_t   itemQ [$];
  logic [7:0] outQ [$];
  logic [7:0] accM;
  int         total = 0;
  int         bad   = 0;
  bit         run   = 1'b0;

  always #4 clk = ~clk;

  assign instrWord = prog[progAddr[5:0]];
  assign inPort    = 8'(progAddr * 8'd29 + 8'd7);

  seq_core u_dut (
    .clk(clk), .rst(rst), .instrWord(instrWord), .inPort(inPort),
    .progAddr(progAddr), .outPort(outPort), .accOut(accOut),
    .regLoad(regLoad), .inStrobe(inStrobe), .aluEn(aluEn), .aluOp(aluOp),
    .accWe(accWe), .regWe(regWe), .outStrobe(outStrobe), .wbSel(wbSel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: program image and reference model, pushes expectations (R4 encoding)
  task automatic loadProgram();
    logic [7:0] rfM [32];
    int         pcM;
    for (int i = 0; i < 64; i++) prog[i] = 8'hE0;
    prog[0]  = {3'd1, 5'd3};   // IN r3
    prog[1]  = {3'd1, 5'd9};   // IN r9
    prog[2]  = {3'd0, 5'd3};   // MOV r3
    prog[3]  = {3'd3, 5'd9};   // ADD r9
    prog[4]  = {3'd2, 5'd0};   // OUT
    prog[5]  = {3'd4, 5'd9};   // SUB r9
    prog[6]  = {3'd4, 5'd9};   // SUB r9 (goes below zero)
    prog[7]  = {3'd2, 5'd7};   // OUT
    prog[8]  = {3'd5, 5'd3};   // undefined
    prog[9]  = {3'd1, 5'd31};  // IN r31
    prog[10] = {3'd3, 5'd31};  // ADD r31 (carry out)
    prog[11] = 8'hFF;          // undefined
    prog[12] = {3'd2, 5'd1};   // OUT
    prog[13] = {3'd0, 5'd0};   // MOV r0
    prog[14] = {3'd2, 5'd0};   // OUT
    prog[15] = {3'd1, 5'd0};   // IN r0
    prog[16] = {3'd6, 5'd0};   // undefined
    prog[17] = {3'd0, 5'd0};   // MOV r0
    prog[18] = {3'd3, 5'd0};   // ADD r0
    prog[19] = {3'd2, 5'd0};   // OUT
    for (int i = 0; i < 32; i++) rfM[i] = 8'd0;
    accM = 8'd0;
    pcM  = 0;
    itemQ.push_back('{len: 2, writes: 0, alus: 0, ins: 0, sub: 0});
    for (int n = 0; n < 26; n++) begin
      logic [7:0] iw;
      logic [4:0] a;
      iw = prog[pcM];
      a  = iw[4:0];
      pcM++;
      case (iw[7:5])
        3'd0: begin accM = rfM[a];
          itemQ.push_back('{len: 5, writes: 1, alus: 0, ins: 0, sub: 0}); end
        3'd1: begin rfM[a] = 8'(pcM * 29 + 7);
          itemQ.push_back('{len: 5, writes: 1, alus: 0, ins: 1, sub: 0}); end
        3'd2: begin outQ.push_back(accM);
          itemQ.push_back('{len: 5, writes: 1, alus: 0, ins: 0, sub: 0}); end
        3'd3: begin accM = accM + rfM[a];
          itemQ.push_back('{len: 6, writes: 1, alus: 1, ins: 0, sub: 0}); end
        3'd4: begin accM = accM - rfM[a];
          itemQ.push_back('{len: 6, writes: 1, alus: 1, ins: 0, sub: 1}); end
        default: itemQ.push_back('{len: 5, writes: 0, alus: 0, ins: 0, sub: -1});
      endcase
    end
  endtask

  // monitor: pops expectations as the design runs
  initial begin
    logic [7:0] lastAddr;
    logic [7:0] holdVal;
    bit         pendOut;
    int         cnt, wr, al, ib, subSeen;
    lastAddr = 8'd0; holdVal = 8'd0; pendOut = 1'b0;
    cnt = 0; wr = 0; al = 0; ib = 0; subSeen = 0;
    wait (run);
    forever begin
      @(negedge clk);
      if (progAddr != lastAddr) begin
        chk(progAddr == 8'(lastAddr + 8'd1), "R2", "pc step", progAddr, 8'(lastAddr + 8'd1));
        if (itemQ.size() > 0) begin
          expItem_t e;
          e = itemQ.pop_front();
          chk(cnt == e.len, "R3", "cycles per instruction", cnt, e.len);
          if (e.sub < 0) begin
            chk(wr == 0, "R9", "writes by undefined opcode", wr, 0);
            chk(al == 0, "R9", "alu use by undefined opcode", al, 0);
          end else begin
            chk(wr == e.writes, "R10", "write strobes", wr, e.writes);
            chk(al == e.alus, "R7", "alu enable cycles", al, e.alus);
            if (e.alus > 0) chk(subSeen == e.sub, "R7", "alu op", subSeen, e.sub);
          end
          chk(ib == e.ins, "R6", "input strobes", ib, e.ins);
        end
        lastAddr = progAddr;
        cnt = 0; wr = 0; al = 0; ib = 0;
      end
      cnt++;
      wr += int'(accWe) + int'(regWe) + int'(outStrobe);
      al += int'(aluEn);
      ib += int'(inStrobe);
      if (aluEn) subSeen = int'(aluOp);
      begin
        int expSel;
        expSel = accWe ? 1 : regWe ? 2 : outStrobe ? 3 : 0;
        chk(int'(wbSel) == expSel, "R10", "write target code", wbSel, expSel);
      end
      if (pendOut) begin
        if (outQ.size() > 0) begin
          logic [7:0] ev;
          ev = outQ.pop_front();
          chk(outPort == ev, "R8", "output value", outPort, ev);
        end else chk(1'b0, "R8", "unexpected output write", outPort, 0);
        holdVal = outPort;
      end else begin
        chk(outPort == holdVal, "R8", "output hold", outPort, holdVal);
      end
      pendOut = outStrobe;
    end
  end

  initial begin
    int waited;
    loadProgram();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(progAddr == 8'd0, "R1", "reset address", progAddr, 0);
    chk(outPort == 8'd0 && accOut == 8'd0, "R1", "reset data", {outPort, accOut}, 0);
    chk({regLoad, inStrobe, aluEn, accWe, regWe, outStrobe} == 6'd0 && wbSel == 2'd0,
        "R1", "reset strobes", {regLoad, inStrobe, aluEn, accWe, regWe, outStrobe, wbSel}, 0);
    rst = 1'b0;
    run = 1'b1;
    @(negedge clk);
    chk(progAddr == 8'd0 && wbSel == 2'd0 && !aluEn, "R1", "first decode after reset",
        progAddr, 0);
    waited = 0;
    while (itemQ.size() > 0 && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    if (itemQ.size() > 0) chk(1'b0, "R3", "watchdog expired", itemQ.size(), 0);
    repeat (8) @(negedge clk);
    chk(outQ.size() == 0, "R8", "outputs missing", outQ.size(), 0);
    chk(accOut == accM, "R5", "final accumulator", accOut, accM);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule